// File: doc/BRIEF.md
# IR Receiver Register Window

This block is the runtime register file of a consumer-infrared receiver, placed at a relocatable I/O base. A host reaches five byte-wide registers through a simple read/write strobe bus: an event/status register, a receive-data port, a transmit control register, a transmit data holding register and a control register that sets the receive idle limit. An IR front end, outside this block, pushes sample bytes into a 32-entry receive FIFO. Each byte is a pulse or space duration counted in 50 microsecond units, and this block stores it without interpreting it.

The host drains received samples by reading the receive-data port until the two receive flags in the status register read clear. Status mixes a plain read/write interrupt enable with four event flags. The transmit flags are write-one-to-clear. The receive flags follow the FIFO and cannot be removed while data remains in it. A single interrupt line is raised while the enable is set and any event is pending. When the logical device is disabled, every register reads 0xFF and host accesses have no effect.

Top module: `irrx_regwin`

## Requirements
- R1: After reset, status reads 0x00, TX control reads 0x00, TX data reads 0x00, control reads IDLE_RESET (default 0x14), the FIFO is empty and irq is low.
- R2: Register offsets are 0 status, 1 RX data, 2 TX control, 3 TX data, 4 control. TX data and control are plain 8-bit read/write registers. Offsets 5 to 7 read 0x00 and ignore writes.
- R3: The RX FIFO holds 32 bytes and returns them in arrival order. A read of offset 1 returns the oldest byte and removes it. A read with the FIFO empty returns 0x00 and changes nothing. A push into a full FIFO drops the byte.
- R4: Status bit 0 (RX received) reads 1 whenever the FIFO holds at least one byte and 0 once it is empty. Writing 1 to it while data is held has no effect.
- R5: Status bit 1 (RX timeout) becomes 1 exactly L+1 clock cycles after the clock edge of the most recent push, while data is still held. L is the value of the control register. The bit reads 0 once the FIFO is empty, and writing 1 to it while data is held has no effect.
- R6: Status bit 7 (interrupt enable) is a plain read/write bit. Status bits 6 to 4 always read 0.
- R7: A tx_done pulse sets status bit 3 (TX finished). A tx_underrun pulse sets status bit 2 (TX underrun). Writing 1 to either bit clears it. An event in the same cycle as its clear leaves the bit set.
- R8: TX control bit 7 (start) and bit 6 (all data written) are written by the host. Bit 7 clears itself on a tx_done pulse. TX control bits 5 to 0 read 0.
- R9: irq is high exactly when status bit 7 is set and at least one of status bits 3 to 0 reads 1.
- R10: While dev_en is low, every offset reads 0xFF. Host reads pop nothing and host writes change no register.
- R11: Writing 0x0F to status clears both TX event flags without touching the interrupt enable bit's stored value beyond setting it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_en | input | 1 | Logical device enable; low blocks host access |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_rd | input | 1 | Host read strobe; a read of offset 1 pops the FIFO |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| smp_push | input | 1 | Front-end sample push strobe |
| smp_data | input | 8 | Sample byte (duration in 50 us units, pulse flag in bit 7) |
| tx_done | input | 1 | Transmit finished event pulse |
| tx_underrun | input | 1 | Transmit underrun event pulse |
| irq | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check that the FIFO occupancy stays within its depth. They check that a push into a full FIFO leaves it full, and that a disabled device neither pops nor loses data. They also check that tx_done lands in the TX finished flag and clears the start bit, and that clearing the enable drops irq on the next cycle. The bench scenarios cover the checks that need the data path and exact timing. These include the ordering of popped bytes and the 0x00 returned by an empty read. They also include the exact cycle at which the idle timeout appears, the write-one-to-clear priority against a simultaneous event, and the 0xFF readback while disabled.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

    localparam int DW = 8;

    // register offsets
    localparam logic [2:0] OFF_STATUS = 3'd0;
    localparam logic [2:0] OFF_RXDATA = 3'd1;
    localparam logic [2:0] OFF_TXCTRL = 3'd2;
    localparam logic [2:0] OFF_TXDATA = 3'd3;
    localparam logic [2:0] OFF_CTRL   = 3'd4;

    // status bit positions
    localparam int ST_IRQEN  = 7;
    localparam int ST_TXFIN  = 3;
    localparam int ST_TXUNF  = 2;

    // TX control bit positions
    localparam int TXC_START = 7;
    localparam int TXC_END   = 6;

    typedef struct packed {
        logic          irq_en;
        logic          tx_fin;
        logic          tx_unf;
        logic          rx_tout;
        logic          tx_start;
        logic          tx_end;
        logic [DW-1:0] tx_data;
        logic [DW-1:0] idle_lim;
    } regs_t;

endpackage

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
    parameter  int DEPTH = 32,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fstate_t;

    fstate_t s_d, s_q;
    logic    do_pop, do_push;
    logic [DW-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && ((s_q.cnt != CW'(DEPTH)) || do_pop);
        if (do_pop)  s_d.rd = step(s_q.rd);
        if (do_push) s_d.wr = step(s_q.wr);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wr] <= din;
    end

    assign head  = mem[s_q.rd];
    assign count = s_q.cnt;

endmodule

// File: rtl/irrx_idle_timer.sv
module irrx_idle_timer #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          active,
    input  logic [LW-1:0] limit,
    output logic          expired
);

    logic [LW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || !active)   cnt_d = '0;
        else if (cnt_q == '1)     cnt_d = cnt_q;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = active && (cnt_q == limit);

endmodule

// File: rtl/irrx_regwin.sv
module irrx_regwin
    import irrx_pkg::*;
#(
    parameter  int          FIFO_DEPTH = 32,
    parameter  logic [7:0]  IDLE_RESET = 8'h14,
    localparam int          CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_en,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       smp_push,
    input  logic [7:0] smp_data,
    input  logic       tx_done,
    input  logic       tx_underrun,
    output logic       irq
);

    regs_t          r_d, r_q;
    logic           wr_ok, rd_ok, pop;
    logic [1:0]     tx_clr;
    logic [DW-1:0]  fifo_head;
    logic [CW-1:0]  fifo_cnt;
    logic           has_data, idle_hit;
    logic [DW-1:0]  status_rd, rdmux;

    assign wr_ok    = dev_en && bus_wr;
    assign rd_ok    = dev_en && bus_rd;
    assign pop      = rd_ok && (bus_addr == OFF_RXDATA);
    assign has_data = (fifo_cnt != '0);

    irrx_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (smp_push),
        .din   (smp_data),
        .pop   (pop),
        .head  (fifo_head),
        .count (fifo_cnt)
    );

    irrx_idle_timer #(.LW(DW)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (smp_push),
        .active  (has_data),
        .limit   (r_q.idle_lim),
        .expired (idle_hit)
    );

    // next-state computation
    always_comb begin
        r_d    = r_q;
        tx_clr = (wr_ok && (bus_addr == OFF_STATUS)) ?
                 bus_wdata[ST_TXFIN:ST_TXUNF] : 2'b00;
        if (wr_ok) begin
            case (bus_addr)
                OFF_STATUS: r_d.irq_en = bus_wdata[ST_IRQEN];
                OFF_TXCTRL: begin
                    r_d.tx_start = bus_wdata[TXC_START];
                    r_d.tx_end   = bus_wdata[TXC_END];
                end
                OFF_TXDATA: r_d.tx_data  = bus_wdata;
                OFF_CTRL:   r_d.idle_lim = bus_wdata;
                default: ;
            endcase
        end
        // events win over a clear in the same cycle
        r_d.tx_fin  = tx_done     || (r_q.tx_fin && !tx_clr[1]);
        r_d.tx_unf  = tx_underrun || (r_q.tx_unf && !tx_clr[0]);
        if (tx_done) r_d.tx_start = 1'b0;
        // receive timeout follows the FIFO, never host-clearable with data held
        r_d.rx_tout = has_data && (r_q.rx_tout || idle_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.idle_lim <= IDLE_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    // read path
    assign status_rd = {r_q.irq_en, 3'b000, r_q.tx_fin, r_q.tx_unf,
                        r_q.rx_tout && has_data, has_data};

    always_comb begin
        case (bus_addr)
            OFF_STATUS: rdmux = status_rd;
            OFF_RXDATA: rdmux = has_data ? fifo_head : '0;
            OFF_TXCTRL: rdmux = {r_q.tx_start, r_q.tx_end, 6'b000000};
            OFF_TXDATA: rdmux = r_q.tx_data;
            OFF_CTRL:   rdmux = r_q.idle_lim;
            default:    rdmux = '0;
        endcase
    end

    assign bus_rdata = dev_en ? rdmux : 8'hFF;
    assign irq       = r_q.irq_en && (r_q.tx_fin || r_q.tx_unf || has_data);

endmodule

// File: rtl/irrx_chk.sv
module irrx_chk #(
    parameter  int DEPTH = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dev_en,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [2:0]    bus_addr,
    input logic          wbit7,
    input logic          smp_push,
    input logic          tx_done,
    input logic          irq,
    input logic [CW-1:0] fifo_cnt,
    input logic          tx_fin,
    input logic          tx_start
);

    logic host_pop;
    assign host_pop = dev_en && bus_rd && (bus_addr == 3'd1);

    // R3: occupancy bounded by the depth
    assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R3: a push into a full FIFO without a pop is dropped
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_push && fifo_cnt == CW'(DEPTH) && !host_pop) |=> fifo_cnt == CW'(DEPTH));

    // R4: an empty FIFO with no push stays empty
    assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0 && !smp_push) |=> fifo_cnt == '0);

    // R10: disabled device reads never pop
    assert_disabled_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_en && !smp_push) |=> $stable(fifo_cnt));

    // R7 and R8: tx_done sets finished and clears start
    assert_txdone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> (tx_fin && !tx_start));

    // R9: clearing the enable silences irq
    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_en && bus_wr && bus_addr == 3'd0 && !wbit7) |=> !irq);

endmodule

bind irrx_regwin irrx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_en   (dev_en),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .wbit7    (bus_wdata[7]),
    .smp_push (smp_push),
    .tx_done  (tx_done),
    .irq      (irq),
    .fifo_cnt (fifo_cnt),
    .tx_fin   (r_q.tx_fin),
    .tx_start (r_q.tx_start)
);

// File: tb/irrx_regwin_tb.sv
module irrx_regwin_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_en = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       smp_push = 1'b0;
    logic [7:0] smp_data = 8'h00;
    logic       tx_done = 1'b0;
    logic       tx_underrun = 1'b0;
    logic       irq;

    int tests = 0;
    int fails = 0;
    logic [7:0] mq[$];
    logic [7:0] v;

    always #10 clk = ~clk;

    irrx_regwin u_dut (
        .clk(clk), .rst_n(rst_n), .dev_en(dev_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smp_push(smp_push), .smp_data(smp_data),
        .tx_done(tx_done), .tx_underrun(tx_underrun), .irq(irq)
    );

    function automatic logic [7:0] exp_status(input bit en, input bit fin,
                                              input bit unf, input bit tout,
                                              input int n);
        return {en, 3'b000, fin, unf, tout && (n != 0), n != 0};
    endfunction

    function automatic bit exp_irq(input bit en, input bit fin, input bit unf, input int n);
        return en && (fin || unf || n != 0);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        smp_push = 1'b1; smp_data = d;
        @(posedge clk); @(negedge clk);
        smp_push = 1'b0;
    endtask

    task automatic pulse_done();
        tx_done = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic pulse_unf();
        tx_underrun = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_underrun = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        peek(3'd0, v); chk("R1 status", v, exp_status(0, 0, 0, 0, 0));
        peek(3'd2, v); chk("R1 txctrl", v, 8'h00);
        peek(3'd3, v); chk("R1 txdata", v, 8'h00);
        peek(3'd4, v); chk("R1 ctrl", v, 8'h14);
        peek(3'd1, v); chk("R1 rxdata empty", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R2 plain registers and unused offsets
        wr(3'd3, 8'hA5); peek(3'd3, v); chk("R2 txdata", v, 8'hA5);
        wr(3'd4, 8'h33); peek(3'd4, v); chk("R2 ctrl", v, 8'h33);
        wr(3'd5, 8'h55); peek(3'd5, v); chk("R2 offset5", v, 8'h00);
        peek(3'd7, v); chk("R2 offset7", v, 8'h00);

        // R8 TX control bits
        wr(3'd2, 8'hFF); peek(3'd2, v); chk("R8 txctrl bits", v, 8'hC0);

        // R6 enable bit, upper bits zero
        wr(3'd0, 8'hF0); peek(3'd0, v); chk("R6 enable only", v, exp_status(1, 0, 0, 0, 0));
        chk("R9 irq idle", {7'd0, irq}, 8'h00);

        // R7 / R8 / R9 transmit events
        pulse_done();
        peek(3'd0, v); chk("R7 tx finished", v, exp_status(1, 1, 0, 0, 0));
        peek(3'd2, v); chk("R8 start self-clear", v, 8'h40);
        chk("R9 irq on event", {7'd0, irq}, {7'd0, exp_irq(1, 1, 0, 0)});
        pulse_unf();
        peek(3'd0, v); chk("R7 tx underrun", v, exp_status(1, 1, 1, 0, 0));
        wr(3'd0, 8'h8F);
        peek(3'd0, v); chk("R11 clear all", v, exp_status(1, 0, 0, 0, 0));
        chk("R9 irq cleared", {7'd0, irq}, 8'h00);

        // R7 set wins over simultaneous clear
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h88; tx_done = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; tx_done = 1'b0;
        peek(3'd0, v); chk("R7 set beats clear", v, exp_status(1, 1, 0, 0, 0));
        wr(3'd0, 8'h0F);
        peek(3'd0, v); chk("R11 0x0F write", v, exp_status(0, 0, 0, 0, 0));
        pulse_unf();
        chk("R9 irq masked", {7'd0, irq}, 8'h00);
        wr(3'd0, 8'h04);

        // R3 / R4 fill past full, order, empty read
        wr(3'd4, 8'hFF);
        wr(3'd0, 8'h80);
        for (int i = 0; i < 33; i++) push(8'(i + 1));
        peek(3'd0, v); chk("R4 rx received", v, exp_status(1, 0, 0, 0, 32));
        chk("R9 irq on data", {7'd0, irq}, {7'd0, exp_irq(1, 0, 0, 32)});
        wr(3'd0, 8'h83);
        peek(3'd0, v); chk("R4 w1c ignored with data", v, exp_status(1, 0, 0, 0, 32));
        for (int i = 0; i < 32; i++) begin
            rd(3'd1, v); chk("R3 fifo order", v, 8'(i + 1));
        end
        peek(3'd0, v); chk("R4 drained", v, exp_status(1, 0, 0, 0, 0));
        rd(3'd1, v); chk("R3 empty read", v, 8'h00);

        // R5 idle timeout timing
        wr(3'd4, 8'd5);
        push(8'h2A);
        idle(5);
        peek(3'd0, v); chk("R5 before limit", v, exp_status(1, 0, 0, 0, 1));
        idle(1);
        peek(3'd0, v); chk("R5 at limit", v, exp_status(1, 0, 0, 1, 1));
        wr(3'd0, 8'h82);
        peek(3'd0, v); chk("R5 w1c ignored", v, exp_status(1, 0, 0, 1, 1));
        rd(3'd1, v); chk("R5 data", v, 8'h2A);
        peek(3'd0, v); chk("R5 cleared on drain", v, exp_status(1, 0, 0, 0, 0));

        // R10 disabled device
        wr(3'd4, 8'hFF);
        push(8'h11); push(8'h22);
        dev_en = 1'b0;
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), v); chk("R10 reads FF", v, 8'hFF);
        end
        rd(3'd1, v);
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h07);
        dev_en = 1'b1;
        peek(3'd0, v); chk("R10 status kept", v, exp_status(1, 0, 0, 0, 2));
        peek(3'd4, v); chk("R10 ctrl kept", v, 8'hFF);
        rd(3'd1, v); chk("R10 no pop", v, 8'h11);
        rd(3'd1, v); chk("R10 second", v, 8'h22);

        // constrained random push/pop against a queue model (R3, R4, R9)
        seed = $urandom(32'd24681357);
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5) begin
                logic [7:0] b;
                b = 8'($urandom_range(0, 255));
                push(b);
                if (mq.size() < 32) mq.push_back(b);
            end else if (op < 8) begin
                logic [7:0] e;
                e = (mq.size() != 0) ? mq.pop_front() : 8'h00;
                rd(3'd1, v); chk("R3 random pop", v, e);
            end else begin
                peek(3'd0, v);
                chk("R4 random status", v & 8'h81, exp_status(1, 0, 0, 0, mq.size()) & 8'h81);
                chk("R9 random irq", {7'd0, irq}, {7'd0, exp_irq(1, 0, 0, mq.size())});
            end
        end
        while (mq.size() != 0) begin
            logic [7:0] e;
            e = mq.pop_front();
            rd(3'd1, v); chk("R3 final drain", v, e);
        end
        peek(3'd0, v); chk("R4 final empty", v & 8'h81, 8'h80);

        summary();
        $finish;
    end

endmodule